// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Serializer

This block produces a fixed answer-to-reset bit stream for a card-style serial memory. The reset pin, the serial clock pin and two internal flags are sampled on a fast system clock. A reset pulse with a clock pulse inside it arms the stream. Once the reset pin falls, bit 0 is driven. Each later serial clock pulse steps to the next bit. After the last bit the block goes back to standby.

The answer word is an elaboration parameter. Its default carries the bytes 19h, 40h, AAh and 55h, sent in that order. Each byte goes out least significant bit first. The output pair is a data bit and an enable for an open-drain pad.

The block sorts each reset pulse into one of three outcomes:
- If it overlaps a clock pulse, the stream restarts from bit 0.
- If it has no clock overlap, the stream is aborted.
- If a nonvolatile write is in progress, the answer is blocked.

A power-fail flag aborts the stream at once.

Top module: `atr_serializer`

## Requirements
- R1: After system reset, and whenever the block is in standby, `sdo_oe_o` is 0 and `sdo_o` is 1 (pad released).
- R2: Stream bit i is bit i of parameter `ATR_WORD`. The default is 32'h55AA4019, so the byte 19h goes first, LSB first, and the first eight bits are 1,0,0,1,1,0,0,0.
- R3: A pulse on `atr_rst_i` during which `scl_i` was sampled high for at least one cycle starts the stream. One cycle after the sample in which `atr_rst_i` is seen low again, `sdo_oe_o` is 1 and `sdo_o` carries bit 0.
- R4: While sending with `atr_rst_i` low, each falling edge of `scl_i` advances one bit, one cycle after the sample. A falling edge while the last bit is shown returns the block to standby.
- R5: If `wr_busy_i` is 1 in the sample where `atr_rst_i` falls, the block goes to standby instead of starting.
- R6: An overlapping reset pulse in the middle of the stream restarts it at bit 0.
- R7: A reset pulse with no clock overlap, mid-stream, puts the block in standby one cycle after the falling sample.
- R8: `pwr_fail_i` high forces standby on the next cycle and overrides every other input.
- R9: Falling edges of `scl_i` while `atr_rst_i` is high, or while in standby, do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous system reset |
| atr_rst_i | input | 1 | Card reset pin level |
| scl_i | input | 1 | Serial clock pin level |
| wr_busy_i | input | 1 | Nonvolatile write cycle in progress |
| pwr_fail_i | input | 1 | Power interruption flag |
| sdo_o | output | 1 | Serial answer bit (1 when released) |
| sdo_oe_o | output | 1 | Pad pull-down enable for the open-drain pin |

## Verification
Every pin edge is detected against the value held one cycle earlier. Each result therefore reaches the outputs on the first system clock edge after the sample that shows the edge: start, step, abort and power-fail all have a latency of exactly one cycle. The bench changes inputs on falling clock edges. It advances a queue-based model on each rising edge and compares both outputs on the next falling edge, so each cycle's expected value lines up with the edge that produced it. Separate checks read back whole streams bit by bit after each serial clock pulse has settled, and compare them with the byte list.

// File: rtl/atr_pkg.sv
package atr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } atr_state_e;

    localparam int unsigned ATR_BITS_DEF = 32;
    localparam logic [31:0] ATR_WORD_DEF = 32'h55AA4019;
endpackage

// File: rtl/atr_edge.sv
module atr_edge #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_s;

    edge_s r_d, r_q;

    always_comb begin
        r_d.prev = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise_o[g] =  lvl_i[g] & ~r_q.prev[g];
        assign fall_o[g] = ~lvl_i[g] &  r_q.prev[g];
    end
endmodule

// File: rtl/atr_window.sv
module atr_window (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_lvl_i,
    input  logic rst_rise_i,
    input  logic scl_lvl_i,
    output logic overlap_o
);
    typedef struct packed {
        logic hit;
    } win_s;

    win_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rst_rise_i) r_d.hit = scl_lvl_i;
        else            r_d.hit = r_q.hit | (rst_lvl_i & scl_lvl_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign overlap_o = r_q.hit;
endmodule

// File: rtl/atr_seq.sv
module atr_seq
    import atr_pkg::*;
#(
    parameter int unsigned          NBITS = ATR_BITS_DEF,
    parameter logic [NBITS-1:0]     WORD  = ATR_WORD_DEF[NBITS-1:0]
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_lvl_i,
    input  logic rst_fall_i,
    input  logic scl_fall_i,
    input  logic overlap_i,
    input  logic wr_busy_i,
    input  logic pwr_fail_i,
    output logic sdo_o,
    output logic oe_o
);
    localparam int unsigned IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBITS - 1);

    typedef struct packed {
        atr_state_e       st;
        logic [IDX_W-1:0] idx;
    } seq_s;

    seq_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (pwr_fail_i) begin
            r_d.st  = ST_IDLE;
            r_d.idx = '0;
        end else if (rst_fall_i) begin
            r_d.idx = '0;
            r_d.st  = (overlap_i && !wr_busy_i) ? ST_SEND : ST_IDLE;
        end else if (r_q.st == ST_SEND && scl_fall_i && !rst_lvl_i) begin
            if (r_q.idx == LAST) begin
                r_d.st  = ST_IDLE;
                r_d.idx = '0;
            end else begin
                r_d.idx = r_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, idx: '0};
        else        r_q <= r_d;
    end

    assign oe_o  = (r_q.st == ST_SEND);
    assign sdo_o = oe_o ? WORD[r_q.idx] : 1'b1;

    // R8
    pwr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> !oe_o);

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_fall_i && overlap_i && !wr_busy_i && !pwr_fail_i) |=> (oe_o && r_q.idx == '0));

    // R5
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_fall_i && wr_busy_i) |=> !oe_o);

    // R7
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_fall_i && !overlap_i) |=> !oe_o);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && rst_lvl_i && !pwr_fail_i) |=> $stable(r_q.idx));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && scl_fall_i && !rst_lvl_i && !rst_fall_i && !pwr_fail_i && r_q.idx != LAST)
        |=> (oe_o && r_q.idx == $past(r_q.idx) + 1'b1));

    // R1
    released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> sdo_o);
endmodule

// File: rtl/atr_serializer.sv
module atr_serializer
    import atr_pkg::*;
#(
    parameter int unsigned      NBITS    = ATR_BITS_DEF,
    parameter logic [NBITS-1:0] ATR_WORD = ATR_WORD_DEF[NBITS-1:0]
) (
    input  logic clk,
    input  logic rst_n,
    input  logic atr_rst_i,
    input  logic scl_i,
    input  logic wr_busy_i,
    input  logic pwr_fail_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam int unsigned PIN_RST = 0;
    localparam int unsigned PIN_SCL = 1;

    logic [1:0] pin_rise, pin_fall;
    logic       overlap;

    atr_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({scl_i, atr_rst_i}),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    atr_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_lvl_i  (atr_rst_i),
        .rst_rise_i (pin_rise[PIN_RST]),
        .scl_lvl_i  (scl_i),
        .overlap_o  (overlap)
    );

    atr_seq #(.NBITS(NBITS), .WORD(ATR_WORD)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_lvl_i  (atr_rst_i),
        .rst_fall_i (pin_fall[PIN_RST]),
        .scl_fall_i (pin_fall[PIN_SCL]),
        .overlap_i  (overlap),
        .wr_busy_i  (wr_busy_i),
        .pwr_fail_i (pwr_fail_i),
        .sdo_o      (sdo_o),
        .oe_o       (sdo_oe_o)
    );
endmodule

// File: tb/atr_serializer_tb.sv
`timescale 1ns/1ps
module atr_serializer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic atr_rst = 1'b0, scl = 1'b0, wr_busy = 1'b0, pwr_fail = 1'b0;
    logic sdo, sdo_oe;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    bit     m_active = 1'b0;
    bit     m_win = 1'b0, m_prev_rst = 1'b0, m_prev_scl = 1'b0;
    bit     m_q[$];
    bit     ref_bits[$];

    always #2.5 clk = ~clk;

    atr_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .atr_rst_i(atr_rst), .scl_i(scl),
        .wr_busy_i(wr_busy), .pwr_fail_i(pwr_fail),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    // behavioural reference: queue of remaining answer bits
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_win = 0; m_prev_rst = 0; m_prev_scl = 0;
            m_q.delete();
        end else begin
            bit rr, rf, sf;
            rr = atr_rst && !m_prev_rst;
            rf = !atr_rst && m_prev_rst;
            sf = !scl && m_prev_scl;
            if (pwr_fail) begin
                m_active = 0; m_q.delete();
            end else if (rf) begin
                m_q.delete();
                if (m_win && !wr_busy) begin
                    m_q = ref_bits;
                    m_active = 1;
                end else m_active = 0;
            end else if (m_active && sf && !atr_rst) begin
                void'(m_q.pop_front());
                if (m_q.size() == 0) m_active = 0;
            end
            if (rr) m_win = scl;
            else    m_win = m_win | (atr_rst & scl);
            m_prev_rst = atr_rst;
            m_prev_scl = scl;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_oe, exp_sdo;
            exp_oe  = m_active;
            exp_sdo = m_active ? m_q[0] : 1'b1;
            n_vec++;
            if (sdo_oe !== exp_oe || sdo !== exp_sdo) begin
                n_bad++;
                $display("FAIL %s: oe/sdo = %b/%b expected %b/%b at %0t",
                         cur_req, sdo_oe, sdo, exp_oe, exp_sdo, $time);
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clk_pulse();
        scl = 1'b1; wait_cyc(2);
        scl = 1'b0; wait_cyc(2);
    endtask

    task automatic reset_pulse(bit with_clk);
        atr_rst = 1'b1; wait_cyc(1);
        if (with_clk) begin scl = 1'b1; wait_cyc(2); scl = 1'b0; end
        wait_cyc(1);
        atr_rst = 1'b0; wait_cyc(2);
    endtask

    task automatic collect(int n, output logic [31:0] word);
        word = '0;
        for (int i = 0; i < n; i++) begin
            word[i] = sdo;
            if (i == 0 && sdo_oe !== 1'b1) check("R3", {31'b0, sdo_oe}, 32'd1);
            clk_pulse();
        end
    endtask

    initial begin
        logic [31:0] got;
        logic [7:0]  bytes [4] = '{8'h19, 8'h40, 8'hAA, 8'h55};
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 8; k++) ref_bits.push_back(bytes[b][k]);

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        cur_req = "R1";
        check("R1", {30'b0, sdo_oe, sdo}, 32'd1);

        // R9: clock pulses in standby have no effect
        cur_req = "R9";
        clk_pulse(); clk_pulse();
        check("R9", {30'b0, sdo_oe, sdo}, 32'd1);

        // R3 / R2 / R4: full answer
        cur_req = "R2";
        reset_pulse(1);
        collect(8, got);
        check("R2", got & 32'hFF, 32'h19);
        cur_req = "R4";
        for (int i = 0; i < 24; i++) clk_pulse();
        check("R4", {30'b0, sdo_oe, sdo}, 32'd1);

        cur_req = "R2";
        reset_pulse(1);
        collect(32, got);
        check("R2", got, 32'h55AA4019);
        check("R4", {31'b0, sdo_oe}, 32'd0);

        // R5: write busy blocks the start
        cur_req = "R5";
        wr_busy = 1'b1;
        reset_pulse(1);
        wr_busy = 1'b0;
        check("R5", {30'b0, sdo_oe, sdo}, 32'd1);
        clk_pulse();
        check("R5", {31'b0, sdo_oe}, 32'd0);

        // R6: restart mid-stream
        cur_req = "R6";
        reset_pulse(1);
        for (int i = 0; i < 5; i++) clk_pulse();
        reset_pulse(1);
        collect(8, got);
        check("R6", got & 32'hFF, 32'h19);

        // R7: abort mid-stream without clock overlap
        cur_req = "R7";
        reset_pulse(0);
        check("R7", {30'b0, sdo_oe, sdo}, 32'd1);
        clk_pulse();
        check("R7", {31'b0, sdo_oe}, 32'd0);

        // R9: clock toggles while reset high do not step (overlap then restarts)
        cur_req = "R9";
        reset_pulse(1);
        clk_pulse(); clk_pulse();
        atr_rst = 1'b1; wait_cyc(1);
        scl = 1'b1; wait_cyc(1); scl = 1'b0; wait_cyc(1);
        scl = 1'b1; wait_cyc(1); scl = 1'b0; wait_cyc(1);
        atr_rst = 1'b0; wait_cyc(2);
        collect(4, got);
        check("R9", got & 32'hF, 32'h9);

        // R8: power fail mid-stream and at the reset fall
        cur_req = "R8";
        reset_pulse(1);
        clk_pulse(); clk_pulse(); clk_pulse();
        pwr_fail = 1'b1; wait_cyc(1); pwr_fail = 1'b0; wait_cyc(1);
        check("R8", {30'b0, sdo_oe, sdo}, 32'd1);
        atr_rst = 1'b1; scl = 1'b1; wait_cyc(2); scl = 1'b0; wait_cyc(1);
        atr_rst = 1'b0; pwr_fail = 1'b1; wait_cyc(1); pwr_fail = 1'b0; wait_cyc(2);
        check("R8", {31'b0, sdo_oe}, 32'd0);

        cur_req = "R1";
        wait_cyc(4);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule